// File: doc/BRIEF.md
# SPI Write-Protection Controller with Region Locking

This block is the command front end of a 512-byte serial memory on an SPI mode 0 slave port. It takes 8-bit instructions MSB first and keeps a write-enable latch. It also holds a 3-bit region-lock code that picks which address span refuses writes. Every array write request is checked against that span before it is granted. When a write passes the check, the block raises a one-cycle grant strobe with a 9-bit address and a data byte. A downstream array would consume that strobe.

A fixed-length busy timer stands in for the nonvolatile storage. Committed writes and committed lock updates start this timer. While it runs, the only command accepted is the status read. The status byte is the only data shifted out on SO.

The SPI pins are sampled by the system clock `clk_i`. SCK must therefore stay in each level for several clock cycles.

Top module: `spi_wp_top`

## Requirements
- R1: Mode 0 timing. SI is taken on each SCK rising edge while CS is low, MSB first. The first bit is the first rising edge after CS falls. SO changes only after SCK falling edges.
- R2: Status read is opcode 05h. The SO bits that follow, sampled on the next eight rising edges, form {busy, write-enable, 000, lock[2:0]}. Bit 7 is sent first.
- R3: Opcode 06h sets the write-enable latch. Opcode 04h clears it. Each takes effect only when CS rises after exactly one whole byte.
- R4: Write is opcode 02h, then an address-high byte (only bit 0 is used, as address bit 8), then the address-low byte, then the data byte. CS must rise after exactly four bytes. If the latch is set and the address is not locked, the result is a one-cycle `wr_grant_o` pulse carrying the address and data. The latch is also cleared. With the latch clear, no grant is issued.
- R5: Lock code map. 0 locks nothing. 1 locks 000h–07Fh, 2 locks 080h–0FFh, 3 locks 100h–17Fh and 4 locks 180h–1FFh. 5 locks 000h–0FFh, 6 locks 000h–00Fh and 7 locks 1F0h–1FFh.
- R6: A write to a locked address gives no grant and starts no busy period. The latch is left unchanged.
- R7: Set-lock is opcode 1Fh followed by one or more bytes, and it requires the latch to be set. At CS rise the last byte's bits [2:0] become the lock code. Busy starts and the latch clears.
- R8: If the last set-lock byte has any nonzero bit in [7:3], the lock code is left unchanged and no busy period starts. The latch is still cleared.
- R9: Busy stays high for exactly BUSY_CYCLES clock cycles after a commit. It starts in the grant cycle. While busy, every command except the status read is ignored.
- R10: The following cause no effect: CS rising in the middle of a byte, a wrong byte count, or an unknown opcode.
- R11: SCK may stop for any length of time while CS is low, and shifting then resumes.
- R12: After reset, the latch is clear, the lock code is 0, busy is low and no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock, idles low |
| si_i | input | 1 | SPI serial data in |
| so_o | output | 1 | SPI serial data out (status only) |
| wr_grant_o | output | 1 | One-cycle strobe for an accepted array write |
| wr_addr_o | output | 9 | Address of the granted write |
| wr_data_o | output | 8 | Data of the granted write |
| busy_o | output | 1 | Nonvolatile update in progress |

## Verification
The busy countdown and the status read can be active at the same time. To provoke this, the bench issues a status read right after a granted write. It expects bit 7 of the returned byte to be 1 and the latch bit to be 0. A write-enable sent during the same busy window must leave the latch clear once busy ends, which shows that commit gating and status shifting do not interfere. The lock gate and the commit decision also act in the same cycle as CS rises. This is checked by sweeping every lock code against addresses just inside and just outside each span.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam int ADDR_W = 9;
  localparam int LOCK_W = 3;
  localparam int NB_W   = 3;

  localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI  = 8'h04;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_SETLK = 8'h1F;
endpackage

// File: rtl/spi_wp_shifter.sv
module spi_wp_shifter
  import spi_wp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              so_load_i,
  input  logic [BYTE_W-1:0] so_data_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [NB_W-1:0]   byte_idx_o,
  output logic              cs_rise_o,
  output logic              aligned_o,
  output logic [NB_W-1:0]   nbytes_o,
  output logic              so_o
);
  logic cs_q, cs_d, sck_q, sck_d, si_q;
  logic rise, fall;
  logic [BIT_CW-1:0] bit_cnt;
  logic [BYTE_W-1:0] in_sr, out_sr;
  logic [NB_W-1:0]   nbytes;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b1; cs_d <= 1'b1;
      sck_q <= 1'b0; sck_d <= 1'b0; si_q <= 1'b0;
    end else begin
      cs_q <= cs_ni; cs_d <= cs_q;
      sck_q <= sck_i; sck_d <= sck_q; si_q <= si_i;
    end
  end

  assign rise      = !cs_q && sck_q && !sck_d;
  assign fall      = !cs_q && !sck_q && sck_d;
  assign cs_rise_o = cs_q && !cs_d;
  assign aligned_o = (bit_cnt == '0);
  assign nbytes_o  = nbytes;

  // input byte assembly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0; in_sr <= '0; nbytes <= '0;
      byte_vld_o <= 1'b0; byte_o <= '0; byte_idx_o <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (cs_q) begin
        bit_cnt <= '0;
        nbytes  <= '0;
      end else if (rise) begin
        in_sr   <= {in_sr[BYTE_W-2:0], si_q};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BIT_CW'(BYTE_W-1)) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {in_sr[BYTE_W-2:0], si_q};
          byte_idx_o <= nbytes;
          if (nbytes != '1) nbytes <= nbytes + 1'b1;
        end
      end
    end
  end

  // output shifting on falling edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sr <= '0; so_o <= 1'b0;
    end else if (cs_q) begin
      out_sr <= '0; so_o <= 1'b0;
    end else if (so_load_i) begin
      out_sr <= so_data_i;
    end else if (fall) begin
      so_o   <= out_sr[BYTE_W-1];
      out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_wp_lock_gate.sv
module spi_wp_lock_gate
  import spi_wp_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int EDGE = 16
) (
  input  logic [LOCK_W-1:0] code_i,
  input  logic [AW-1:0]     addr_i,
  output logic              locked_o
);
  localparam int TOP = 1 << AW;
  logic [1:0] quarter;
  int unsigned a;

  assign quarter = addr_i[AW-1:AW-2];
  assign a       = 32'(addr_i);

  always_comb begin
    unique case (code_i)
      3'd1:    locked_o = (quarter == 2'd0);
      3'd2:    locked_o = (quarter == 2'd1);
      3'd3:    locked_o = (quarter == 2'd2);
      3'd4:    locked_o = (quarter == 2'd3);
      3'd5:    locked_o = !addr_i[AW-1];
      3'd6:    locked_o = (a < EDGE);
      3'd7:    locked_o = (a >= TOP - EDGE);
      default: locked_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
  import spi_wp_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [NB_W-1:0]   byte_idx_i,
  input  logic              cs_rise_i,
  input  logic              aligned_i,
  input  logic [NB_W-1:0]   nbytes_i,
  input  logic              locked_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LOCK_W-1:0] lock_o,
  output logic              wel_o,
  output logic              so_load_o,
  output logic [BYTE_W-1:0] so_data_o,
  output logic              wr_grant_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [BYTE_W-1:0] op_q, pend_q, dat_q, alo_q;
  logic              ahi_q;
  logic [CNT_W-1:0]  busy_cnt;
  logic              go;

  assign busy_o    = (busy_cnt != '0);
  assign addr_o    = {ahi_q, alo_q};
  assign go        = cs_rise_i && aligned_i && (nbytes_i != '0) && !busy_o;
  assign so_load_o = byte_vld_i && (byte_idx_i == '0) && (byte_i == OP_RDSR);
  assign so_data_o = {busy_o, wel_o, {(BYTE_W-2-LOCK_W){1'b0}}, lock_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= '0; pend_q <= '0; dat_q <= '0; alo_q <= '0; ahi_q <= 1'b0;
      busy_cnt <= '0; wel_o <= 1'b0; lock_o <= '0;
      wr_grant_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
    end else begin
      wr_grant_o <= 1'b0;
      if (busy_o) busy_cnt <= busy_cnt - 1'b1;
      if (byte_vld_i) begin
        case (byte_idx_i)
          3'd0:    op_q  <= byte_i;
          3'd1:    ahi_q <= byte_i[0];
          3'd2:    alo_q <= byte_i;
          3'd3:    dat_q <= byte_i;
          default: ;
        endcase
        if (byte_idx_i != '0) pend_q <= byte_i;
      end
      if (go) begin
        case (op_q)
          OP_WREN: if (nbytes_i == 3'd1) wel_o <= 1'b1;
          OP_WRDI: if (nbytes_i == 3'd1) wel_o <= 1'b0;
          OP_WRITE:
            if (nbytes_i == 3'd4 && wel_o && !locked_i) begin
              wr_grant_o <= 1'b1;
              wr_addr_o  <= addr_o;
              wr_data_o  <= dat_q;
              wel_o      <= 1'b0;
              busy_cnt   <= CNT_W'(BUSY_CYCLES);
            end
          OP_SETLK:
            if (nbytes_i >= 3'd2 && wel_o) begin
              wel_o <= 1'b0;
              if (pend_q[BYTE_W-1:LOCK_W] == '0) begin
                lock_o   <= pend_q[LOCK_W-1:0];
                busy_cnt <= CNT_W'(BUSY_CYCLES);
              end
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_wp_top.sv
module spi_wp_top
  import spi_wp_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              wr_grant_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              busy_o
);
  logic              byte_vld, cs_rise, aligned, so_load, locked, wel;
  logic [BYTE_W-1:0] byte_val, so_data;
  logic [NB_W-1:0]   byte_idx, nbytes;
  logic [ADDR_W-1:0] req_addr;
  logic [LOCK_W-1:0] lock_code;

  spi_wp_shifter u_shift (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .so_load_i (so_load),  .so_data_i (so_data),
    .byte_vld_o(byte_vld), .byte_o    (byte_val),
    .byte_idx_o(byte_idx), .cs_rise_o (cs_rise),
    .aligned_o (aligned),  .nbytes_o  (nbytes),
    .so_o
  );

  spi_wp_lock_gate u_gate (
    .code_i(lock_code), .addr_i(req_addr), .locked_o(locked)
  );

  spi_wp_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .byte_i   (byte_val), .byte_idx_i(byte_idx),
    .cs_rise_i (cs_rise),  .aligned_i(aligned),  .nbytes_i  (nbytes),
    .locked_i  (locked),   .addr_o   (req_addr), .lock_o    (lock_code),
    .wel_o     (wel),      .so_load_o(so_load),  .so_data_o (so_data),
    .wr_grant_o, .wr_addr_o, .wr_data_o, .busy_o
  );
endmodule

// File: rtl/spi_wp_checker.sv
module spi_wp_checker #(
  parameter int BUSY_CYCLES = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       busy_i,
  input logic       grant_i,
  input logic       wel_i,
  input logic [2:0] lock_i
);
  int unsigned busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run <= 0;
    else if (busy_i) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  assert_grant_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> !grant_i);
  assert_grant_after_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> $past(cs_ni));
  assert_grant_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> busy_i);
  assert_busy_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_run == BUSY_CYCLES);
  assert_busy_clears_wel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !wel_i);
  assert_lock_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lock_i) |-> $rose(busy_i));
endmodule

bind spi_wp_top spi_wp_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_ni  (cs_ni),
  .busy_i (busy_o),
  .grant_i(wr_grant_o),
  .wel_i  (wel),
  .lock_i (lock_code)
);

// File: tb/tb_spi_wp_top.sv
module tb_spi_wp_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int BUSY_CYC = 300;
  localparam int ADDRS[12] = '{0, 15, 16, 127, 128, 255, 256, 383, 384, 495, 496, 511};

  logic clk = 0, rst_ni = 0, cs_ni = 1, sck = 0, si = 0;
  logic so, grant, busy;
  logic [8:0] waddr;
  logic [7:0] wdata;
  int n_chk = 0, n_fail = 0;
  int g_cnt = 0, run = 0, last_run = 0;
  logic [8:0] g_addr;
  logic [7:0] g_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_wp_top #(.BUSY_CYCLES(BUSY_CYC)) dut (
    .clk_i(clk), .rst_ni, .cs_ni, .sck_i(sck), .si_i(si), .so_o(so),
    .wr_grant_o(grant), .wr_addr_o(waddr), .wr_data_o(wdata), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (grant) begin g_cnt++; g_addr = waddr; g_data = wdata; end
    if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); si = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = so; sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic cs_begin(); @(negedge clk); cs_ni = 0; repeat (2) @(negedge clk); endtask
  task automatic cs_end();   repeat (2) @(negedge clk); cs_ni = 1; repeat (6) @(negedge clk); endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_begin(); spi_byte(op, r); cs_end();
  endtask

  task automatic do_write(input logic [8:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_begin();
    spi_byte(8'h02, r); spi_byte({7'b0, a[8]}, r); spi_byte(a[7:0], r); spi_byte(d, r);
    cs_end();
  endtask

  task automatic set_lock(input logic [7:0] b);
    logic [7:0] r;
    cs_begin(); spi_byte(8'h1F, r); spi_byte(b, r); cs_end();
  endtask

  task automatic rd_status(output logic [7:0] st);
    logic [7:0] r;
    cs_begin(); spi_byte(8'h05, r); spi_byte(8'h00, st); cs_end();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic exp_locked(input int code, input int a);
    case (code)
      1: return a < 128;
      2: return a >= 128 && a < 256;
      3: return a >= 256 && a < 384;
      4: return a >= 384;
      5: return a < 256;
      6: return a < 16;
      7: return a >= 496;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_reset();
    logic [7:0] st;
    check(!busy && !grant && !so, "R12 outputs", {busy, grant, so}, 0);
    rd_status(st);
    check(st == 8'h00, "R12 status", st, 8'h00);
  endtask

  task automatic t_wel();
    logic [7:0] st;
    cmd1(8'h06); rd_status(st);
    check(st == 8'h40, "R3 wren", st, 8'h40);
    cmd1(8'h04); rd_status(st);
    check(st == 8'h00, "R3 wrdi", st, 8'h00);
  endtask

  task automatic t_write_no_wel();
    int g0 = g_cnt;
    do_write(9'h155, 8'h3C);
    check(g_cnt == g0 && !busy, "R4 no wel", g_cnt - g0, 0);
  endtask

  task automatic t_write_busy();
    logic [7:0] st;
    int g0 = g_cnt;
    cmd1(8'h06);
    do_write(9'h1A7, 8'hC3);
    check(g_cnt == g0 + 1, "R4 grant", g_cnt - g0, 1);
    check(g_addr == 9'h1A7 && g_data == 8'hC3, "R1 R4 addr/data", {g_addr, g_data}, {9'h1A7, 8'hC3});
    rd_status(st);
    check(st == 8'h80, "R2 R9 status while busy", st, 8'h80);
    cmd1(8'h06);
    wait_idle();
    check(last_run == BUSY_CYC, "R9 busy length", last_run, BUSY_CYC);
    rd_status(st);
    check(st == 8'h00, "R9 wren ignored while busy", st, 8'h00);
  endtask

  task automatic t_lock_basic();
    logic [7:0] st;
    int g0;
    cmd1(8'h06); set_lock(8'h02);
    check(busy, "R7 lock busy", busy, 1);
    wait_idle(); rd_status(st);
    check(st == 8'h02, "R7 lock stored", st, 8'h02);
    cmd1(8'h06); g0 = g_cnt;
    do_write(9'h0A5, 8'h11);
    check(g_cnt == g0 && !busy, "R6 locked write", g_cnt - g0, 0);
    rd_status(st);
    check(st == 8'h42, "R6 wel kept", st, 8'h42);
    do_write(9'h07F, 8'h22);
    check(g_cnt == g0 + 1 && g_addr == 9'h07F, "R6 unlocked write", g_addr, 9'h07F);
    wait_idle();
  endtask

  task automatic t_lock_reject();
    logic [7:0] st;
    cmd1(8'h06); set_lock(8'h0B);
    check(!busy, "R8 no busy", busy, 0);
    rd_status(st);
    check(st == 8'h02, "R8 lock unchanged wel cleared", st, 8'h02);
    set_lock(8'h05); rd_status(st);
    check(st == 8'h02, "R7 needs wel", st, 8'h02);
  endtask

  task automatic t_lock_multi();
    logic [7:0] st, r;
    cmd1(8'h06);
    cs_begin(); spi_byte(8'h1F, r); spi_byte(8'h03, r); spi_byte(8'h06, r); cs_end();
    wait_idle(); rd_status(st);
    check(st == 8'h06, "R7 last byte wins", st, 8'h06);
  endtask

  task automatic t_abort();
    logic [7:0] st, r;
    cs_begin();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); si = 1'b0; repeat (HALF) @(negedge clk); sck = 1;
      repeat (HALF) @(negedge clk); sck = 0;
    end
    cs_end(); rd_status(st);
    check(st == 8'h06, "R10 partial byte", st, 8'h06);
    cs_begin(); spi_byte(8'h06, r); spi_byte(8'h00, r); cs_end(); rd_status(st);
    check(st == 8'h06, "R10 wren two bytes", st, 8'h06);
    cmd1(8'hAB); rd_status(st);
    check(st == 8'h06, "R10 unknown opcode", st, 8'h06);
  endtask

  task automatic t_pause();
    logic [7:0] r;
    int g0;
    cmd1(8'h06); g0 = g_cnt;
    cs_begin(); spi_byte(8'h02, r); spi_byte(8'h00, r);
    repeat (150) @(negedge clk);
    spi_byte(8'h5A, r);
    repeat (90) @(negedge clk);
    spi_byte(8'h99, r); cs_end();
    check(g_cnt == g0 + 1 && g_addr == 9'h05A && g_data == 8'h99, "R11 sck pause",
          {g_addr, g_data}, {9'h05A, 8'h99});
    wait_idle();
  endtask

  task automatic t_sweep();
    for (int c = 1; c < 8; c++) begin
      cmd1(8'h06); set_lock(8'(c)); wait_idle();
      for (int k = 0; k < 12; k++) begin
        int g0;
        logic exp_g;
        cmd1(8'h06); g0 = g_cnt;
        do_write(9'(ADDRS[k]), 8'(ADDRS[k]) ^ 8'hA5);
        exp_g = !exp_locked(c, ADDRS[k]);
        check((g_cnt - g0) == int'(exp_g), $sformatf("R5 code %0d addr %0h", c, ADDRS[k]),
              g_cnt - g0, int'(exp_g));
        wait_idle();
      end
    end
    cmd1(8'h06); set_lock(8'h00); wait_idle();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_wel();
    t_write_no_wel();
    t_write_busy();
    t_lock_basic();
    t_lock_reject();
    t_lock_multi();
    t_abort();
    t_pause();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule